// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is an 8-bit event counter for a microcontroller timer. It advances only on a timer tick. The tick is an enable pulse taken from one of five taps on a free-running prescaler, or from a synchronised edge on an external pin. A 3-bit clock-select value picks the source, and the value zero stops the timer. On each tick, a 3-bit counting-mode input decides the next value:

- The normal mode counts up.
- The dual-slope mode counts up to the maximum and then back down to zero.
- The down mode counts down.

A clear control forces the count to zero, and a CPU write loads the count directly.

The count is always visible on an output, whether or not ticks arrive. Two outputs show when the count is at its maximum and when it is at zero. An overflow flag is set at the point the counting mode defines, and it can serve as an interrupt request. Software clears the flag by writing a one to it, and an interrupt-acknowledge pulse also clears it.

The counting direction is held in a two-state machine. `DIR_UP` is entered at reset, on a clear, at the turning tick at zero in dual-slope mode, and on any tick in a mode other than dual-slope or down. `DIR_DOWN` is entered at the turning tick at the maximum in dual-slope mode, and on any tick in down mode. A CPU write leaves the state unchanged.

Top module: `updn_timer_core`

## Requirements
- R1: While reset is asserted, and after it is released with no tick, the count is 0x00, the overflow flag is 0 and the direction output is 0 (up).
- R2: With clock select 0, the count holds. Selects 1, 2, 3, 4 and 5 tick on prescaler states whose low 0, 3, 6, 8 or 10 bits are all ones. The prescaler is a 10-bit counter that starts at zero at reset release, so the dividers are 1, 8, 64, 256 and 1024.
- R3: Select 6 ticks on a falling edge of the external pin and select 7 on a rising edge. The pin passes through two synchronising flops, so the count changes at the third rising clock edge after the pin changes.
- R4: In mode 0, and in modes 3 to 7, each tick increments the count. A tick at 0xFF wraps the count to 0x00 and sets the overflow flag at the same edge.
- R5: In mode 1, each tick increments the count while the direction is up. A tick at 0xFF goes to 0xFE and turns the direction down. While the direction is down, each tick decrements the count. A tick at 0x00 goes to 0x01, turns the direction up and sets the overflow flag.
- R6: In mode 2, each tick decrements the count and sets the direction output to 1. A tick at 0x00 wraps the count to 0xFF and sets the overflow flag.
- R7: A clear pulse without a CPU write sets the count to 0x00 and the direction to up at the next edge, whether or not a tick is present. It does not set the overflow flag.
- R8: A CPU write loads the count at the next edge and outranks a clear and a tick in the same cycle. That cycle makes no count step, no direction change and no overflow.
- R9: `at_top` is 1 exactly when the count is 0xFF, and `at_bottom` is 1 exactly when the count is 0x00, with no delay.
- R10: A write-one-to-clear pulse or an acknowledge pulse clears the overflow flag at the next edge. A new overflow in the same cycle takes precedence, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Tick source: 0 stop, 1-5 prescaler taps, 6 pin falling, 7 pin rising |
| ext_pin | input | 1 | Asynchronous external event pin |
| mode | input | 3 | Counting mode: 0 normal, 1 dual-slope, 2 down, others normal |
| cnt_clr | input | 1 | Clear request for count and direction |
| bus_wr | input | 1 | CPU write strobe for the count |
| bus_wdata | input | 8 | CPU write data |
| ovf_w1c | input | 1 | Software write of one to the overflow flag |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Overflow flag / interrupt request |
| dir_down | output | 1 | Direction state, 1 when counting down |
| at_top | output | 1 | Count equals 0xFF |
| at_bottom | output | 1 | Count equals 0x00 |

## Verification
The count, the direction and the overflow flag each change at the first rising edge after the cycle that carries the write, the clear or the tick. The one exception is a pin-sourced tick, which lands at the third edge after the pin moves. The top and bottom outputs follow the count within the same cycle. The bench drives every input at the falling edge and advances a cycle-exact model at the rising edge, including its own prescaler and synchroniser. It compares all outputs at the next falling edge, so each result is sampled one half-cycle after the edge that is due to produce it.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

    // Counting modes; encodings not listed behave as WM_NORMAL.
    typedef enum logic [2:0] {
        WM_NORMAL = 3'd0,
        WM_DUAL   = 3'd1,
        WM_DOWN   = 3'd2
    } wave_mode_e;

    // Direction state machine.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;

    // Tick source selection.
    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_DIV1     = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    localparam int NUM_TAPS = 5;

endpackage

// File: rtl/updn_tmr_tick.sv
module updn_tmr_tick
    import updn_tmr_pkg::*;
#(
    parameter int LOG_D1 = 0,
    parameter int LOG_D2 = 3,
    parameter int LOG_D3 = 6,
    parameter int LOG_D4 = 8,
    parameter int LOG_D5 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    input  logic       ext_pin,
    output logic       tick
);

    localparam int PRE_W = LOG_D5;
    localparam int TAP_LOG [NUM_TAPS] = '{LOG_D1, LOG_D2, LOG_D3, LOG_D4, LOG_D5};

    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] tap;
    logic                sync1_q, sync2_q, prev_q;
    logic                pin_fall, pin_rise;

    // Free-running prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // One enable per divider: low bits of the prescaler all ones
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << TAP_LOG[i]) - 64'd1);
        assign tap[i] = &(pre_q | ~MASK);
    end

    // Pin synchroniser plus edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= ext_pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign pin_fall = prev_q & ~sync2_q;
    assign pin_rise = sync2_q & ~prev_q;

    always_comb begin
        unique case (clk_sel_e'(clk_sel))
            CS_STOP:     tick = 1'b0;
            CS_DIV1:     tick = tap[0];
            CS_DIV8:     tick = tap[1];
            CS_DIV64:    tick = tap[2];
            CS_DIV256:   tick = tap[3];
            CS_DIV1024:  tick = tap[4];
            CS_EXT_FALL: tick = pin_fall;
            CS_EXT_RISE: tick = pin_rise;
            default:     tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/updn_tmr_count.sv
module updn_tmr_count
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [2:0]       mode,
    input  logic             clr,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             ovf_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    dir_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             step;

    assign step = tick & ~wr & ~clr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIR_UP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Next state, next count and overflow event
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ovf_evt = 1'b0;
        if (wr) begin
            cnt_d = wdata;
        end else if (clr) begin
            cnt_d   = '0;
            state_d = DIR_UP;
        end else if (step) begin
            unique case (wave_mode_e'(mode))
                WM_DUAL: begin
                    unique case (state_q)
                        DIR_UP: begin
                            if (cnt_q == CNT_MAX) begin
                                cnt_d   = CNT_MAX - CNT_ONE;
                                state_d = DIR_DOWN;
                            end else begin
                                cnt_d = cnt_q + CNT_ONE;
                            end
                        end
                        DIR_DOWN: begin
                            if (cnt_q == '0) begin
                                cnt_d   = CNT_ONE;
                                state_d = DIR_UP;
                                ovf_evt = 1'b1;
                            end else begin
                                cnt_d = cnt_q - CNT_ONE;
                            end
                        end
                        default: state_d = DIR_UP;
                    endcase
                end
                WM_DOWN: begin
                    cnt_d   = cnt_q - CNT_ONE;
                    state_d = DIR_DOWN;
                    ovf_evt = (cnt_q == '0);
                end
                default: begin
                    cnt_d   = cnt_q + CNT_ONE;
                    state_d = DIR_UP;
                    ovf_evt = (cnt_q == CNT_MAX);
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        cnt      = cnt_q;
        dir_down = (state_q == DIR_DOWN);
    end

endmodule

// File: rtl/updn_tmr_flag.sv
module updn_tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic w1c,
    input  logic ack,
    output logic flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag <= 1'b0;
        else if (set_evt)    flag <= 1'b1;
        else if (w1c || ack) flag <= 1'b0;
    end

endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic             ext_pin,
    input  logic [2:0]       mode,
    input  logic             cnt_clr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic             ovf_w1c,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_flag,
    output logic             dir_down,
    output logic             at_top,
    output logic             at_bottom
);

    logic tick;
    logic ovf_evt;

    updn_tmr_tick u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .ext_pin (ext_pin),
        .tick    (tick)
    );

    updn_tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode),
        .clr      (cnt_clr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .cnt      (cnt_q),
        .dir_down (dir_down),
        .ovf_evt  (ovf_evt)
    );

    updn_tmr_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (ovf_evt),
        .w1c     (ovf_w1c),
        .ack     (irq_ack),
        .flag    (ovf_flag)
    );

    assign at_top    = &cnt_q;
    assign at_bottom = ~|cnt_q;

endmodule

// File: rtl/updn_tmr_checker.sv
module updn_tmr_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       clk_sel,
    input logic [2:0]       mode,
    input logic             cnt_clr,
    input logic             bus_wr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             ovf_w1c,
    input logic             irq_ack,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_flag,
    input logic             dir_down
);

    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (cnt_q == $past(bus_wdata)));

    a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0 && !bus_wr && !cnt_clr) |=> $stable(cnt_q) && $stable(dir_down));

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr && !bus_wr) |=> (cnt_q == '0 && !dir_down));

    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_w1c || irq_ack) && clk_sel == 3'd0) |=> !ovf_flag);

    a_r4_flag_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_flag) && $past(mode) == 3'd0) |-> (cnt_q == '0));

endmodule

bind updn_timer_core updn_tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .mode      (mode),
    .cnt_clr   (cnt_clr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .ovf_w1c   (ovf_w1c),
    .irq_ack   (irq_ack),
    .cnt_q     (cnt_q),
    .ovf_flag  (ovf_flag),
    .dir_down  (dir_down)
);

// File: tb/tb_updn_timer_core.sv
`timescale 1ns/1ps
module tb_updn_timer_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic       ext_pin = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       cnt_clr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       ovf_w1c = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] cnt_q;
    logic       ovf_flag, dir_down, at_top, at_bottom;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    updn_timer_core dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_pin(ext_pin),
        .mode(mode), .cnt_clr(cnt_clr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .ovf_w1c(ovf_w1c), .irq_ack(irq_ack), .cnt_q(cnt_q), .ovf_flag(ovf_flag),
        .dir_down(dir_down), .at_top(at_top), .at_bottom(at_bottom)
    );

    // ---------------- reference model ----------------
    logic [9:0] m_pre;
    logic       m_s1, m_s2, m_s3;
    logic [7:0] m_cnt;
    logic       m_dn, m_ovf;

    function automatic logic m_tick(logic [2:0] s, logic [9:0] p, logic a, logic b);
        case (s)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return &p[2:0];
            3'd3: return &p[5:0];
            3'd4: return &p[7:0];
            3'd5: return &p;
            3'd6: return !a && b;
            default: return a && !b;
        endcase
    endfunction

    // returns {overflow, direction, count}
    function automatic logic [9:0] m_next(logic [2:0] md, logic dn, logic [7:0] c);
        case (md)
            3'd1: begin
                if (!dn) return (c == 8'hFF) ? {1'b0, 1'b1, 8'hFE} : {1'b0, 1'b0, c + 8'd1};
                else     return (c == 8'h00) ? {1'b1, 1'b0, 8'h01} : {1'b0, 1'b1, c - 8'd1};
            end
            3'd2:    return {c == 8'h00, 1'b1, c - 8'd1};
            default: return {c == 8'hFF, 1'b0, c + 8'd1};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic       t, set;
        logic [9:0] nx;
        if (!rst_n) begin
            m_pre = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_cnt = '0; m_dn = 0; m_ovf = 0;
        end else begin
            t   = m_tick(clk_sel, m_pre, m_s2, m_s3);
            set = 1'b0;
            if (bus_wr) m_cnt = bus_wdata;
            else if (cnt_clr) begin m_cnt = 8'h00; m_dn = 1'b0; end
            else if (t) begin
                nx = m_next(mode, m_dn, m_cnt);
                set = nx[9]; m_dn = nx[8]; m_cnt = nx[7:0];
            end
            if (set) m_ovf = 1'b1;
            else if (ovf_w1c || irq_ack) m_ovf = 1'b0;
            m_pre = m_pre + 10'd1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmp_all(input string req);
        chk({req, " count"}, cnt_q, m_cnt);
        chk({req, " flag"}, ovf_flag, m_ovf);
        chk({req, " dir"}, dir_down, m_dn);
        chk("R9 top", at_top, m_cnt == 8'hFF);
        chk("R9 bottom", at_bottom, m_cnt == 8'h00);
    endtask

    task automatic step(input string req);
        @(posedge clk);
        @(negedge clk);
        cmp_all(req);
        bus_wr = 0; cnt_clr = 0; ovf_w1c = 0; irq_ack = 0;
    endtask

    task automatic run(input string req, input int n);
        for (int i = 0; i < n; i++) step(req);
    endtask

    task automatic load(input logic [7:0] v);
        bus_wr = 1; bus_wdata = v;
        step("R8 load");
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        // R1: reset state
        #23;
        chk("R1 count", cnt_q, 0);
        chk("R1 flag", ovf_flag, 0);
        chk("R1 dir", dir_down, 0);
        @(negedge clk); rst_n = 1;
        run("R1", 3);
        chk("R1 idle count", cnt_q, 8'h00);

        // R4: normal mode wrap with divide-by-1
        mode = 3'd0;
        load(8'hFD);
        clk_sel = 3'd1;
        run("R4", 2);
        chk("R9 top at FF", at_top, 1);
        step("R4");
        chk("R4 wrap count", cnt_q, 8'h00);
        chk("R4 wrap flag", ovf_flag, 1);
        // R10: write-one-to-clear, then ack
        clk_sel = 3'd0; ovf_w1c = 1; step("R10");
        chk("R10 w1c clears", ovf_flag, 0);
        // mode 5 acts as normal
        mode = 3'd5; load(8'hFF); clk_sel = 3'd1; step("R4");
        chk("R4 mode5 flag", ovf_flag, 1);
        clk_sel = 3'd0; irq_ack = 1; step("R10");
        chk("R10 ack clears", ovf_flag, 0);
        // R10: set beats clear
        load(8'hFF); clk_sel = 3'd1; mode = 3'd0; ovf_w1c = 1; step("R10");
        chk("R10 set wins", ovf_flag, 1);
        clk_sel = 3'd0; ovf_w1c = 1; step("R10");

        // R5: dual slope turning at both ends
        mode = 3'd1; load(8'hFD); clk_sel = 3'd1;
        run("R5", 3);
        chk("R5 turn down", dir_down, 1);
        chk("R5 after top", cnt_q, 8'hFE);
        clk_sel = 3'd0; load(8'h02); clk_sel = 3'd1;
        run("R5", 3);
        chk("R5 turn up", cnt_q, 8'h01);
        chk("R5 bottom flag", ovf_flag, 1);
        clk_sel = 3'd0; irq_ack = 1; step("R10");

        // R6: down counting with wrap
        mode = 3'd2; load(8'h01); clk_sel = 3'd1;
        run("R6", 2);
        chk("R6 wrap", cnt_q, 8'hFF);
        chk("R6 flag", ovf_flag, 1);
        chk("R6 dir", dir_down, 1);

        // R7 / R8: clear and write priority
        cnt_clr = 1; step("R7");
        chk("R7 clear", cnt_q, 8'h00);
        chk("R7 dir up", dir_down, 0);
        mode = 3'd0; cnt_clr = 1; bus_wr = 1; bus_wdata = 8'h5A; step("R8");
        chk("R8 write beats clear+tick", cnt_q, 8'h5A);
        bus_wr = 1; bus_wdata = 8'hFF; step("R8");
        bus_wr = 1; bus_wdata = 8'h33; ovf_w1c = 1; step("R8");
        chk("R8 no overflow on write", ovf_flag, 0);

        // R2: stopped, then each prescaler tap
        clk_sel = 3'd0; run("R2 stop", 20);
        chk("R2 hold", cnt_q, 8'h33);
        for (int s = 2; s <= 5; s++) begin
            clk_sel = 3'(s);
            run("R2 prescale", (s == 5) ? 2100 : 300);
        end

        // R3: external pin edges
        for (int s = 6; s <= 7; s++) begin
            clk_sel = 3'(s);
            for (int k = 0; k < 12; k++) begin
                ext_pin = ~ext_pin;
                run("R3", 1 + (k % 4));
            end
        end

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 31) == 0) clk_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 63) == 0) mode = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) ext_pin = ~ext_pin;
            cnt_clr = ($urandom_range(0, 63) == 0);
            bus_wr = ($urandom_range(0, 47) == 0);
            bus_wdata = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 7) == 0) bus_wdata = 8'hFF;
            ovf_w1c = ($urandom_range(0, 15) == 0);
            irq_ack = ($urandom_range(0, 15) == 0);
            step("R4 R5 R6 random");
        end

        done = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

endmodule